// File: doc/BRIEF.md
# PCI Memory Base Address Register

This block is one 32-bit memory Base Address Register on the configuration side of a PCI endpoint. Host software reads and writes it through a configuration port at a single dword offset. The register tells software how large a region the endpoint needs, and it holds the base address that software assigns to that region. Both jobs share the same 32 bits.

The low address bits below log2 of the region size are hardwired to zero. The four least significant bits are fixed type bits. To find the size, software writes all ones, reads the value back, clears the four type bits, inverts the result and adds one. It then writes back the value it saved before sizing. The register bits above the boundary hold the assigned base. Because the bits below the boundary cannot be set, that base is always aligned to the region size.

A combinational hit output compares an incoming memory address with the programmed base. It looks only at the writable bit positions, so a downstream decoder can claim transactions that fall inside the region.

Top module: `cfg_mem_bar`

## Requirements
- R1: After synchronous reset, every writable base bit is zero, so a read of the register returns 0x00000000.
- R2: Every read of the register returns bit 0 = 0 (memory space), bits 2:1 = 00 (32-bit decoder) and bit 3 = 0 (non-prefetchable).
- R3: Bits 31:0 below log2(REGION_BYTES) always read back as zero, whatever value was written.
- R4: After a write of 0xFFFFFFFF with all byte enables set, a read returns ~(REGION_BYTES-1). For example, a 64 KB region returns 0xFFFF0000.
- R5: A write with all byte enables set stores wdata bits at and above log2(REGION_BYTES). A later read returns wdata & ~(REGION_BYTES-1).
- R6: Byte enable bit k (k = 0..3) gates data bits 8k+7:8k. A write updates only the lanes whose enable is 1. The other lanes keep their previous value.
- R7: A write to any dword offset other than BAR_OFFSET leaves the register unchanged. A read at such an offset returns 0x00000000.
- R8: A read request raises cfg_rd_valid, with cfg_rdata, on the cycle after the request. cfg_rd_valid is low in cycles that follow no request.
- R9: mem_hit is 1 exactly when mem_addr and the stored base agree in every bit at and above log2(REGION_BYTES). It follows mem_addr combinationally.
- R10: After a sizing write, writing back the value saved before sizing makes later reads return that saved value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_dw_addr | input | OFF_W | Dword offset of the configuration access |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Byte enables of the write, one per byte lane |
| cfg_rdata | output | 32 | Registered read data |
| cfg_rd_valid | output | 1 | Read data valid, one cycle after cfg_rd_en |
| mem_addr | input | 32 | Memory transaction address to compare |
| mem_hit | output | 1 | Address falls inside the programmed region |

## Verification
A wrong bit in the stored base shows up in two places. It appears in the very next configuration read, one cycle after the request. It also changes mem_hit at once for any address that sits on that bit boundary. A lane that latches data when its byte enable is low, or a writable bit below the size boundary, alters the readback of the sizing pattern on the next read. Writes are therefore followed straight away by reads and by address sweeps across the region edges, so a bad state cannot hide for more than two cycles.

// File: rtl/memb_pkg.sv
package memb_pkg;
  localparam int DW    = 32;
  localparam int LANES = DW / 8;

  typedef logic [DW-1:0]    dword_t;
  typedef logic [LANES-1:0] lane_en_t;

  // memory space, 32-bit decoder, non-prefetchable
  localparam logic [3:0] TYPE_NIBBLE = 4'b0000;
endpackage

// File: rtl/memb_base_reg.sv
module memb_base_reg
  import memb_pkg::*;
#(
  parameter int ADDR_LSB = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_sel,
  input  dword_t   wdata,
  input  lane_en_t be,
  output dword_t   base_q
);
  localparam dword_t WMASK = ~((dword_t'(1) << ADDR_LSB) - dword_t'(1));

  dword_t lane_next;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_next[8*l +: 8] = (wr_sel && be[l]) ? wdata[8*l +: 8] : base_q[8*l +: 8];

    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (wr_sel && !be[l]) |=> $stable(base_q[8*l +: 8])); // R6
  end

  always_ff @(posedge clk) begin
    if (rst) base_q <= '0;
    else     base_q <= lane_next & WMASK;
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_sel |=> $stable(base_q)); // R7
endmodule

// File: rtl/memb_rd_port.sv
module memb_rd_port
  import memb_pkg::*;
#(
  parameter int ADDR_LSB = 16
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   rd_req,
  input  logic   rd_sel,
  input  dword_t base_q,
  output dword_t rdata,
  output logic   rd_valid
);
  localparam dword_t LOW_MASK = (dword_t'(1) << ADDR_LSB) - dword_t'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      rdata    <= rd_sel ? {base_q[DW-1:4], TYPE_NIBBLE} : '0;
    end
  end

  AST_TYPE_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rdata[3:0] == 4'b0000)); // R2
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ((rdata & LOW_MASK) == '0)); // R3
endmodule

// File: rtl/memb_hit.sv
module memb_hit
  import memb_pkg::*;
#(
  parameter int ADDR_LSB = 16
) (
  input  dword_t base_q,
  input  dword_t addr,
  output logic   hit
);
  always_comb hit = (addr[DW-1:ADDR_LSB] == base_q[DW-1:ADDR_LSB]);
endmodule

// File: rtl/cfg_mem_bar.sv
module cfg_mem_bar
  import memb_pkg::*;
#(
  parameter int REGION_BYTES = 65536,
  parameter int OFF_W        = 6,
  parameter int BAR_OFFSET   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr_en,
  input  logic             cfg_rd_en,
  input  logic [OFF_W-1:0] cfg_dw_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic [3:0]       cfg_be,
  output logic [31:0]      cfg_rdata,
  output logic             cfg_rd_valid,
  input  logic [31:0]      mem_addr,
  output logic             mem_hit
);
  localparam int ADDR_LSB = $clog2(REGION_BYTES);
  localparam logic [OFF_W-1:0] SEL_OFF = OFF_W'(BAR_OFFSET);

  logic   off_match;
  dword_t base_q;

  assign off_match = (cfg_dw_addr == SEL_OFF);

  memb_base_reg #(.ADDR_LSB(ADDR_LSB)) base_i (
    .clk(clk), .rst(rst), .wr_sel(cfg_wr_en && off_match),
    .wdata(cfg_wdata), .be(cfg_be), .base_q(base_q)
  );

  memb_rd_port #(.ADDR_LSB(ADDR_LSB)) rd_i (
    .clk(clk), .rst(rst), .rd_req(cfg_rd_en), .rd_sel(cfg_rd_en && off_match),
    .base_q(base_q), .rdata(cfg_rdata), .rd_valid(cfg_rd_valid)
  );

  memb_hit #(.ADDR_LSB(ADDR_LSB)) hit_i (
    .base_q(base_q), .addr(mem_addr), .hit(mem_hit)
  );

  AST_VALID_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
    cfg_rd_en |=> cfg_rd_valid); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd_en |=> !cfg_rd_valid); // R8
  AST_OFF_TARGET_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd_en && !off_match) |=> (cfg_rdata == 32'h0)); // R7
endmodule

// File: tb/cfg_mem_bar_tb_top.sv
module cfg_mem_bar_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RB = 256;
  localparam int OW = 6;
  localparam int BOFF = 4;
  localparam logic [31:0] WM = ~(32'(RB) - 32'd1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [OW-1:0] dw_addr = '0;
  logic [31:0] wdata = '0, rdata, maddr = '0;
  logic [3:0] be = '0;
  logic rd_valid, hit;

  int n_run = 0, n_fail = 0;
  logic [31:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_mem_bar #(.REGION_BYTES(RB), .OFF_W(OW), .BAR_OFFSET(BOFF)) dut_i (
    .clk(clk), .rst(rst), .cfg_wr_en(wr_en), .cfg_rd_en(rd_en),
    .cfg_dw_addr(dw_addr), .cfg_wdata(wdata), .cfg_be(be),
    .cfg_rdata(rdata), .cfg_rd_valid(rd_valid), .mem_addr(maddr), .mem_hit(hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [OW-1:0] off, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    wr_en = 1'b1; dw_addr = off; wdata = d; be = b;
    @(negedge clk);
    wr_en = 1'b0; be = '0;
  endtask

  task automatic do_read(input logic [OW-1:0] off, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; dw_addr = off;
    @(negedge clk);
    rd_en = 1'b0;
    check("R8 valid", {31'd0, rd_valid}, 32'd1);
    check("R2 type bits", {28'd0, rdata[3:0]}, 32'd0);
    d = rdata;
  endtask

  function automatic logic [31:0] apply(input logic [31:0] cur, input logic [31:0] d,
                                        input logic [3:0] b);
    logic [31:0] r = cur;
    for (int k = 0; k < 4; k++) if (b[k]) r[8*k +: 8] = d[8*k +: 8];
    return r & WM;
  endfunction

  initial begin
    logic [31:0] rv, saved;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 idle valid", {31'd0, rd_valid}, 32'd0);
    do_read(6'(BOFF), rv);
    check("R1 reset value", rv, 32'h0);

    do_write(6'(BOFF), 32'hA5C3_7E11, 4'hF);
    model = apply(model, 32'hA5C3_7E11, 4'hF);
    do_read(6'(BOFF), rv);
    check("R5 programmed base", rv, model);
    check("R3 low bits", rv & ~WM, 32'h0);
    saved = rv;

    do_write(6'(BOFF), 32'hFFFF_FFFF, 4'hF);
    do_read(6'(BOFF), rv);
    check("R4 sizing readback", rv, WM);
    check("R4 derived size", (~(rv & 32'hFFFF_FFF0)) + 32'd1, 32'(RB));
    do_write(6'(BOFF), saved, 4'hF);
    model = saved;
    do_read(6'(BOFF), rv);
    check("R10 restore", rv, saved);

    for (int b = 0; b < 16; b++) begin
      do_write(6'(BOFF), 32'h0, 4'hF);
      do_write(6'(BOFF), 32'hFFFF_FFFF, 4'(b));
      model = apply(32'h0, 32'hFFFF_FFFF, 4'(b));
      do_read(6'(BOFF), rv);
      check("R6 byte lanes", rv, model);
    end

    do_write(6'(BOFF), 32'h1234_5678, 4'hF);
    model = apply(model, 32'h1234_5678, 4'hF);
    for (int o = 0; o < 8; o++) begin
      if (o != BOFF) begin
        do_write(6'(o), 32'hFFFF_FFFF, 4'hF);
        do_read(6'(o), rv);
        check("R7 other offset reads zero", rv, 32'h0);
        do_read(6'(BOFF), rv);
        check("R7 other offset no effect", rv, model);
      end
    end

    for (int k = -6; k <= 10; k++) begin
      @(negedge clk);
      maddr = model + 32'(k * 64);
      #1;
      check("R9 hit", {31'd0, hit}, {31'd0, ((maddr & WM) == (model & WM))});
    end
    maddr = 32'hFFFF_FFFF; #1;
    check("R9 far miss", {31'd0, hit}, 32'd0);

    @(negedge clk);
    check("R8 no request", {31'd0, rd_valid}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule